// File: doc/BRIEF.md
# Two-Digit Vacuum Fluorescent Display Scan and Dimmer Controller

This block multiplexes a vacuum fluorescent display at half duty. It holds a display image of two halves, one for each digit grid, with one bit for each segment. It alternates between the two grid outputs once per half frame. While a grid is lit, the segment outputs carry that digit's half of the image directly, with no character decoding. The frame is derived from a free-running oscillator-clock counter. The first half of each frame belongs to the first grid and the second half to the second grid.

A serial receiver outside this block writes the image and the dimmer settings in parallel with a one-cycle load strobe. The brightness of each grid is a 6-bit code that sets how long the grid stays on after a short guard interval at the start of its slot. A source bit chooses between the code written over the link and the result of an external analog-to-digital converter. Written data and dimmer settings are held pending and become visible only at the next frame boundary. An active-low blanking input darkens the whole display at once. Loads are still accepted while the display is blanked.

Top module: `vfd_scan_dimmer`

## Requirements
- R1: A synchronous reset clears the displayed and pending image to all zeros, selects the written (digital) dimmer source with code 0, and restarts the frame at position 0, which is the start of the first grid's slot.
- R2: A frame lasts 2^FRAME_LOG2 clock cycles. Positions 0 to SLOT-1, where SLOT is half a frame, belong to grid[0], and the remaining positions belong to grid[1]. At most one grid output is high at any time.
- R3: For the first GUARD_CYC positions of each slot, both grid outputs are low.
- R4: With active dimmer code c, the slot's grid is high from slot position GUARD_CYC up to, but not including, position GUARD_CYC + (c+1)*STEP_CYC. The on-time is cut off at the end of the slot when that end position lies beyond it.
- R5: While grid[0] is high, seg equals load_data[SEG_W-1:0]. While grid[1] is high, seg equals load_data[2*SEG_W-1:SEG_W]. Both values come from the image active in the current frame, and a 1 bit lights its segment.
- R6: Whenever both grid outputs are low, seg is all zeros.
- R7: While blank_n is low, grid and seg are all zeros in the same cycle, with no clock edge needed.
- R8: A load_valid strobe is accepted while blank_n is low. When blanking ends, the loaded image and dimmer code are shown.
- R9: An image, source bit or code captured by load_valid, and any change of adc_code, affect the outputs only from the next frame position 0 onward. The current frame keeps the values it started with.
- R10: A load_dim_src value of 0 selects load_dim_code. A value of 1 selects adc_code as sampled at the clock edge that starts the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-derived clock |
| rst | input | 1 | Synchronous reset, active high |
| load_valid | input | 1 | One-cycle strobe that captures the load_* inputs as pending settings |
| load_data | input | 2*SEG_W | Display image; the low half is for grid[0], the high half for grid[1] |
| load_dim_src | input | 1 | Dimmer source: 0 selects the written code, 1 selects the converter result |
| load_dim_code | input | CODE_W | Written dimmer code |
| adc_code | input | CODE_W | Converter result used in analog source mode |
| blank_n | input | 1 | Active-low display blanking |
| grid | output | 2 | Digit grid enables; bit 0 is the first digit |
| seg | output | SEG_W | Segment enables |

## Verification
The bench builds the block with FRAME_LOG2=8, giving a 256-cycle frame and 128-cycle slots, with GUARD_CYC=8 and STEP_CYC=2. SEG_W and CODE_W keep their full widths of 37 and 6. With these values every frame boundary, guard edge and on-time edge can be reached within a few hundred cycles. Code 63 asks for an on-time that runs past the slot end, so the cap is exercised. Codes 0, 1, 5, 7, 10 and 20 each end at a distinct position, so a wrong source selection or a mid-frame update of the active code changes an observed grid value.

// File: rtl/vfd_pkg.sv
package vfd_pkg;

   // Dimmer code source
   typedef enum logic {
      DIM_DIGITAL = 1'b0,
      DIM_ANALOG  = 1'b1
   } dim_src_e;

endpackage

// File: rtl/vfd_frame_timer.sv
module vfd_frame_timer #(
   parameter int FRAME_LOG2 = 12
) (
   input  logic                  clk,
   input  logic                  rst,
   output logic                  digit_sel,
   output logic [FRAME_LOG2-2:0] slot_pos,
   output logic                  frame_end
);

   logic [FRAME_LOG2-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) cnt <= '0;
      else     cnt <= cnt + 1'b1;
   end

   assign digit_sel = cnt[FRAME_LOG2-1];
   assign slot_pos  = cnt[FRAME_LOG2-2:0];
   assign frame_end = &cnt;

endmodule

// File: rtl/vfd_shadow_regs.sv
module vfd_shadow_regs
   import vfd_pkg::*;
#(
   parameter int SEG_W  = 37,
   parameter int CODE_W = 6
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 frame_end,
   input  logic                 load_valid,
   input  logic [2*SEG_W-1:0]   load_data,
   input  logic                 load_dim_src,
   input  logic [CODE_W-1:0]    load_dim_code,
   input  logic [CODE_W-1:0]    adc_code,
   output logic [2*SEG_W-1:0]   act_data,
   output logic [CODE_W-1:0]    act_code
);

   logic [2*SEG_W-1:0] pend_data;
   dim_src_e           pend_src;
   logic [CODE_W-1:0]  pend_code;

   // Pending copy: written at any time, also while blanked
   always_ff @(posedge clk) begin
      if (rst) begin
         pend_data <= '0;
         pend_src  <= DIM_DIGITAL;
         pend_code <= '0;
      end else if (load_valid) begin
         pend_data <= load_data;
         pend_src  <= dim_src_e'(load_dim_src);
         pend_code <= load_dim_code;
      end
   end

   // Active copy: moves only at the frame boundary
   always_ff @(posedge clk) begin
      if (rst) begin
         act_data <= '0;
         act_code <= '0;
      end else if (frame_end) begin
         act_data <= pend_data;
         act_code <= (pend_src == DIM_ANALOG) ? adc_code : pend_code;
      end
   end

   // R9: active settings never move inside a frame
   a_r9_frame_hold: assert property (@(posedge clk) disable iff (rst)
      !frame_end |=> ($stable(act_data) && $stable(act_code)));

endmodule

// File: rtl/vfd_grid_duty.sv
module vfd_grid_duty #(
   parameter int SLOT_LOG2 = 11,
   parameter int CODE_W    = 6,
   parameter int GUARD_CYC = 32,
   parameter int STEP_CYC  = 32
) (
   input  logic [SLOT_LOG2-1:0] slot_pos,
   input  logic [CODE_W-1:0]    act_code,
   output logic                 on
);

   localparam int MAX_END = GUARD_CYC + (2**CODE_W) * STEP_CYC;
   localparam int WW      = $clog2(MAX_END + 1) + 1;
   localparam int SLOT    = 2**SLOT_LOG2;

   logic [WW-1:0] pos_ext;
   logic [WW-1:0] win_end;
   logic          past_guard;

   assign pos_ext    = WW'(slot_pos);
   assign past_guard = (pos_ext >= WW'(GUARD_CYC));

   generate
      if (MAX_END <= SLOT) begin : g_no_cap
         // Every code ends inside the slot
         assign win_end = WW'(GUARD_CYC) + (WW'(act_code) + WW'(1)) * WW'(STEP_CYC);
      end else begin : g_cap
         logic [WW-1:0] raw_end;
         assign raw_end = WW'(GUARD_CYC) + (WW'(act_code) + WW'(1)) * WW'(STEP_CYC);
         assign win_end = (raw_end > WW'(SLOT)) ? WW'(SLOT) : raw_end;
      end
   endgenerate

   assign on = past_guard && (pos_ext < win_end);

endmodule

// File: rtl/vfd_scan_dimmer.sv
module vfd_scan_dimmer #(
   parameter int SEG_W      = 37,
   parameter int CODE_W     = 6,
   parameter int FRAME_LOG2 = 12,
   parameter int GUARD_CYC  = 32,
   parameter int STEP_CYC   = 32,
   parameter bit BLANK_SYNC = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 load_valid,
   input  logic [2*SEG_W-1:0]   load_data,
   input  logic                 load_dim_src,
   input  logic [CODE_W-1:0]    load_dim_code,
   input  logic [CODE_W-1:0]    adc_code,
   input  logic                 blank_n,
   output logic [1:0]           grid,
   output logic [SEG_W-1:0]     seg
);

   localparam int SLOT_LOG2 = FRAME_LOG2 - 1;
   localparam int SLOT      = 2**SLOT_LOG2;

   generate
      if (FRAME_LOG2 < 3) begin : g_bad_frame
         $error("FRAME_LOG2 must be at least 3");
      end
      if (GUARD_CYC < 0 || GUARD_CYC >= SLOT) begin : g_bad_guard
         $error("GUARD_CYC must lie inside one slot");
      end
      if (STEP_CYC < 1) begin : g_bad_step
         $error("STEP_CYC must be positive");
      end
      if (SEG_W < 1 || CODE_W < 1) begin : g_bad_width
         $error("SEG_W and CODE_W must be positive");
      end
   endgenerate

   logic                 digit_sel;
   logic [SLOT_LOG2-1:0] slot_pos;
   logic                 frame_end;
   logic [2*SEG_W-1:0]   act_data;
   logic [CODE_W-1:0]    act_code;
   logic                 slot_on;
   logic                 blank_eff_n;

   vfd_frame_timer #(.FRAME_LOG2(FRAME_LOG2)) u_timer (
      .clk       (clk),
      .rst       (rst),
      .digit_sel (digit_sel),
      .slot_pos  (slot_pos),
      .frame_end (frame_end)
   );

   vfd_shadow_regs #(.SEG_W(SEG_W), .CODE_W(CODE_W)) u_shadow (
      .clk           (clk),
      .rst           (rst),
      .frame_end     (frame_end),
      .load_valid    (load_valid),
      .load_data     (load_data),
      .load_dim_src  (load_dim_src),
      .load_dim_code (load_dim_code),
      .adc_code      (adc_code),
      .act_data      (act_data),
      .act_code      (act_code)
   );

   vfd_grid_duty #(
      .SLOT_LOG2 (SLOT_LOG2),
      .CODE_W    (CODE_W),
      .GUARD_CYC (GUARD_CYC),
      .STEP_CYC  (STEP_CYC)
   ) u_duty (
      .slot_pos (slot_pos),
      .act_code (act_code),
      .on       (slot_on)
   );

   // Blanking path: direct gate or two-flop resynchronised gate
   generate
      if (BLANK_SYNC) begin : g_blank_sync
         logic [1:0] blank_ff;
         always_ff @(posedge clk) begin
            if (rst) blank_ff <= 2'b00;
            else     blank_ff <= {blank_ff[0], blank_n};
         end
         assign blank_eff_n = blank_ff[1];
      end else begin : g_blank_direct
         assign blank_eff_n = blank_n;
         // R7: blanking darkens the grids in the same cycle
         a_r7_blank_dark: assert property (@(posedge clk) disable iff (rst)
            !blank_n |-> (grid == 2'b00 && seg == '0));
      end
   endgenerate

   // Per-digit grid enable and segment contribution
   logic [SEG_W-1:0] seg_part [2];

   generate
      for (genvar d = 0; d < 2; d++) begin : g_digit
         assign grid[d]     = slot_on && (digit_sel == 1'(d)) && blank_eff_n;
         assign seg_part[d] = grid[d] ? act_data[d*SEG_W +: SEG_W] : '0;
      end
   endgenerate

   assign seg = seg_part[0] | seg_part[1];

   // R2: grids never overlap
   a_r2_grid_onehot: assert property (@(posedge clk) disable iff (rst)
      $onehot0(grid));

   // R3: guard interval at the start of each slot keeps grids off
   a_r3_guard_off: assert property (@(posedge clk) disable iff (rst)
      (slot_pos < SLOT_LOG2'(GUARD_CYC)) |-> (grid == 2'b00));

   // R6: segments are dark whenever no grid is on
   a_r6_seg_dark: assert property (@(posedge clk) disable iff (rst)
      (grid == 2'b00) |-> (seg == '0));

endmodule

// File: tb/test_vfd_scan_dimmer.sv
module test_vfd_scan_dimmer;

   localparam int SEG_W  = 37;
   localparam int CODE_W = 6;
   localparam int FL2    = 8;
   localparam int FRAME  = 2**FL2;
   localparam int SLOT   = FRAME / 2;
   localparam int GUARD  = 8;
   localparam int STEP   = 2;

   logic                clk = 1'b0;
   logic                rst = 1'b1;
   logic                load_valid = 1'b0;
   logic [2*SEG_W-1:0]  load_data = '0;
   logic                load_dim_src = 1'b0;
   logic [CODE_W-1:0]   load_dim_code = '0;
   logic [CODE_W-1:0]   adc_code = '0;
   logic                blank_n = 1'b1;
   logic [1:0]          grid;
   logic [SEG_W-1:0]    seg;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;
   int mcnt     = 0;

   always #2 clk = ~clk;

   vfd_scan_dimmer #(
      .SEG_W(SEG_W), .CODE_W(CODE_W), .FRAME_LOG2(FL2),
      .GUARD_CYC(GUARD), .STEP_CYC(STEP), .BLANK_SYNC(1'b0)
   ) i_vfd_scan_dimmer (
      .clk(clk), .rst(rst), .load_valid(load_valid), .load_data(load_data),
      .load_dim_src(load_dim_src), .load_dim_code(load_dim_code),
      .adc_code(adc_code), .blank_n(blank_n), .grid(grid), .seg(seg)
   );

   // Frame position expected from the requirements (R2)
   always @(posedge clk) begin
      if (rst) mcnt <= 0;
      else     mcnt <= (mcnt + 1) % FRAME;
   end

   localparam logic [SEG_W-1:0] PAT_LO  = 37'h15_5555_5555;
   localparam logic [SEG_W-1:0] PAT_HI  = 37'h0A_AAAA_AAAA;
   localparam logic [SEG_W-1:0] PAT2_LO = 37'h00_0000_FFFF;
   localparam logic [SEG_W-1:0] PAT2_HI = 37'h1F_0000_0000;

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic chk_out(input string tag, input logic [1:0] eg, input logic [SEG_W-1:0] es);
      check({tag, " grid"}, 64'(grid), 64'(eg));
      check({tag, " seg"},  64'(seg),  64'(es));
   endtask

   // Advance to the next negedge where the frame position equals p
   task automatic goto(input int p);
      do @(negedge clk); while (mcnt != p);
   endtask

   task automatic load(input logic [SEG_W-1:0] hi, input logic [SEG_W-1:0] lo,
                       input logic src, input logic [CODE_W-1:0] code);
      load_data     = {hi, lo};
      load_dim_src  = src;
      load_dim_code = code;
      load_valid    = 1'b1;
      @(negedge clk);
      load_valid    = 1'b0;
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk_out("R1 pos0 after reset", 2'b00, '0);
      goto(GUARD);
      chk_out("R1 code0 digit1 first", 2'b01, '0);
      goto(GUARD + 1);
      chk_out("R1 code0 last on", 2'b01, '0);
      goto(GUARD + 2);
      chk_out("R1 code0 ends", 2'b00, '0);
   endtask

   task automatic t_digital();
      goto(20);
      load(PAT_HI, PAT_LO, 1'b0, 6'd5);
      goto(SLOT + GUARD);
      chk_out("R9 old image kept", 2'b10, '0);
      goto(SLOT + 10);
      chk_out("R9 old code kept", 2'b00, '0);
      goto(GUARD - 1);
      chk_out("R3 guard off", 2'b00, '0);
      goto(GUARD);
      chk_out("R5 digit1 low half", 2'b01, PAT_LO);
      goto(19);
      chk_out("R4 code5 last on", 2'b01, PAT_LO);
      goto(20);
      chk_out("R4 R6 code5 off dark", 2'b00, '0);
      goto(SLOT + GUARD);
      chk_out("R5 digit2 high half", 2'b10, PAT_HI);
      goto(SLOT + 20);
      chk_out("R4 digit2 code5 off", 2'b00, '0);
   endtask

   task automatic t_cap();
      goto(30);
      load(PAT_HI, PAT_LO, 1'b0, 6'd63);
      goto(0);
      goto(SLOT - 1);
      chk_out("R4 cap on at slot end", 2'b01, PAT_LO);
      goto(SLOT);
      chk_out("R3 guard at digit2 start", 2'b00, '0);
      goto(FRAME - 1);
      chk_out("R2 digit2 in second half", 2'b10, PAT_HI);
      goto(0);
      chk_out("R3 guard at frame start", 2'b00, '0);
      goto(GUARD);
      chk_out("R2 digit1 after wrap", 2'b01, PAT_LO);
   endtask

   task automatic t_analog();
      adc_code = 6'd10;
      goto(30);
      load(PAT_HI, PAT_LO, 1'b1, 6'd3);
      goto(0);
      goto(29);
      chk_out("R10 adc code10 on", 2'b01, PAT_LO);
      goto(30);
      chk_out("R10 adc code10 off", 2'b00, '0);
      goto(40);
      adc_code = 6'd1;
      goto(SLOT + 29);
      chk_out("R9 adc change held", 2'b10, PAT_HI);
      goto(0);
      goto(11);
      chk_out("R10 new adc on", 2'b01, PAT_LO);
      goto(12);
      chk_out("R10 new adc off", 2'b00, '0);
   endtask

   task automatic t_blank();
      goto(30);
      load(PAT_HI, PAT_LO, 1'b0, 6'd20);
      goto(0);
      goto(GUARD);
      chk_out("R10 digital code20 on", 2'b01, PAT_LO);
      goto(20);
      blank_n = 1'b0;
      #1;
      chk_out("R7 blank immediate", 2'b00, '0);
      goto(60);
      load(PAT2_HI, PAT2_LO, 1'b0, 6'd7);
      goto(0);
      goto(10);
      chk_out("R7 still blanked", 2'b00, '0);
      goto(12);
      blank_n = 1'b1;
      #1;
      chk_out("R8 image loaded while blanked", 2'b01, PAT2_LO);
      goto(SLOT + 23);
      chk_out("R8 code7 last on", 2'b10, PAT2_HI);
      goto(SLOT + 24);
      chk_out("R8 code7 off", 2'b00, '0);
   endtask

   task automatic t_midreset();
      goto(50);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      goto(GUARD);
      chk_out("R1 reset clears image", 2'b01, '0);
      goto(GUARD + 2);
      chk_out("R1 reset restores code0", 2'b00, '0);
   endtask

   initial begin
      t_reset();
      t_digital();
      t_cap();
      t_analog();
      t_blank();
      t_midreset();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

endmodule